// File: doc/BRIEF.md
# SD Host Status and Flag Unit

This block is the flag and status unit of an SD-card host controller. It turns the word counts of the transmit and receive FIFOs into level flags (empty, full, half thresholds, data waiting) and folds pulses from the command and data paths into sticky event and error bits. The result is one 32-bit status word. The FIFO storage, CRC logic, card bus protocol and DMA sit outside the block.

Software reads `status_o` and acknowledges events through a write-only clear port. Writing 1 to a bit of that port clears the matching sticky bit. A built-in timer raises the command-response timeout flag when a command that expects a response gets no answer within 64 card-clock ticks. When hardware flow control is on, the transmit-empty and receive-full flags fire two words early. This gives the data path time to stall the card clock.

Top module: `sd_status_unit`

## Requirements
- R1: After reset, all sticky bits (status bits 0 to 8 and 10) read 0. Bits 11 to 20 reflect the live inputs, so with all inputs at zero the status word is 0x000C_4000.
- R2: Bit 15 is 1 when the receive count is at least 8. Bit 14 is 1 when at least 8 words are free in the 16-word transmit FIFO, that is, when the transmit count is at most 8.
- R3: With flow control off, these bits follow the counts:
  - bit 20 is 1 when the transmit count is nonzero;
  - bit 19 is 1 when the receive count is 0;
  - bit 18 is 1 when the transmit count is 0;
  - bit 17 is 1 when the receive count is 16;
  - bit 16 is 1 when the transmit count is 16.
- R4: With `flow_ctrl_i` high, bit 18 is 1 when the transmit count is at most 2, and bit 17 is 1 when the receive count is at least 14.
- R5: A pulse on `evt_i[n]` sets status bit n on the next clock edge, for n in {0,1,3,4,5,6,7,8,10}. The bit then holds until it is cleared.
- R6: A cycle with `clr_we_i` high clears every sticky bit whose `clr_data_i` bit is 1. Bits written 0 are left unchanged.
- R7: Bits 9 and 21 to 31 always read 0. `evt_i[9]` and `evt_i[2]` have no effect on the status word.
- R8: Bits 11, 12 and 13 show `cmd_busy_i`, `tx_busy_i` and `rx_busy_i`. Bits 11 to 20 are not changed by clear writes.
- R9: If an event and a clear hit the same sticky bit in the same cycle, the bit ends up set.
- R10: After a `cmd_issue_i` pulse, bit 2 sets at the 64th `ck_tick_i` cycle if no response arrives. It sets only once per command.
- R11: A response before expiry cancels the timeout. A response is `evt_i[6]` (response received) or `evt_i[0]` (response CRC failed).
- R12: The timeout counts only cycles with `ck_tick_i` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_count_i | input | 5 | Transmit FIFO word count, 0 to 16 |
| rx_count_i | input | 5 | Receive FIFO word count, 0 to 16 |
| flow_ctrl_i | input | 1 | Hardware flow control enable |
| cmd_busy_i | input | 1 | Command transfer in progress |
| tx_busy_i | input | 1 | Data transmit in progress |
| rx_busy_i | input | 1 | Data receive in progress |
| evt_i | input | 11 | Event pulses, bit n sets status bit n |
| cmd_issue_i | input | 1 | Pulse: command sent that expects a response |
| ck_tick_i | input | 1 | One-cycle strobe per card-clock period |
| clr_we_i | input | 1 | Clear register write strobe |
| clr_data_i | input | 32 | Clear mask, 1 clears a bit |
| status_o | output | 32 | Status word |

## Verification
The level flags are driven from a table of count pairs. Some pairs sit exactly on the thresholds 0, 2, 8, 14 and 16, and some sit one word away. Each pair is applied with flow control on and with it off, so an off-by-one compare or a missing flow-control shift shows up. The sticky tests apply these cases:
- all events pulsed at once, to tell the real event bits apart from the ignored positions;
- a partial clear, an all-zero clear and an all-ones clear, to separate sticky bits from live bits;
- a colliding set and clear, to check which one wins.

The timer is run with a steady tick, with a tick every other cycle, and with an early response. Together these pin the expiry to exactly the 64th tick, confirm it fires only once, and confirm the response cancels it.

// File: rtl/sd_stat_pkg.sv
package sd_stat_pkg;
  localparam int STAT_W = 32;
  localparam int EVT_W  = 11;

  localparam int B_CMD_CRC  = 0;
  localparam int B_CMD_TMO  = 2;
  localparam int B_RSP_OK   = 6;
  localparam int B_RSVD     = 9;
  localparam int B_CMD_ACT  = 11;

  // sticky positions: 0..8 and 10
  localparam logic [STAT_W-1:0] STICKY_MASK = 32'h0000_05FF;

  // packed MSB-first so it lands on status bits 20..14
  typedef struct packed {
    logic tx_avail;
    logic rx_empty;
    logic tx_empty;
    logic rx_full;
    logic tx_full;
    logic rx_half;
    logic tx_half;
  } fifo_lvl_t;
endpackage

// File: rtl/sd_fifo_levels.sv
module sd_fifo_levels
  import sd_stat_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int FC_MARGIN = 2,
  localparam int CW       = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] tx_cnt_i,
  input  logic [CW-1:0] rx_cnt_i,
  input  logic          flow_i,
  output fifo_lvl_t     lvl_o
);
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_C = CW'(DEPTH / 2);
  localparam logic [CW-1:0] TXE_FC = CW'(FC_MARGIN);
  localparam logic [CW-1:0] RXF_FC = CW'(DEPTH - FC_MARGIN);

  always_comb begin
    lvl_o.tx_avail = (tx_cnt_i != '0);
    lvl_o.rx_empty = (rx_cnt_i == '0);
    lvl_o.tx_full  = (tx_cnt_i == FULL_C);
    lvl_o.rx_half  = (rx_cnt_i >= HALF_C);
    lvl_o.tx_half  = (tx_cnt_i <= HALF_C);
    lvl_o.tx_empty = flow_i ? (tx_cnt_i <= TXE_FC) : (tx_cnt_i == '0);
    lvl_o.rx_full  = flow_i ? (rx_cnt_i >= RXF_FC) : (rx_cnt_i == FULL_C);
  end

  assert_tx_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lvl_o.tx_full && lvl_o.tx_empty));
  assert_rx_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lvl_o.rx_empty && lvl_o.rx_half));
endmodule

// File: rtl/sd_sticky_bank.sv
module sd_sticky_bank #(
  parameter int          W    = 32,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] set_m, clr_m, q;

  assign set_m = set_i & MASK;
  assign clr_m = clr_we_i ? (clr_i & MASK) : '0;

  // set beats clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) q <= '0;
    else         q <= (q & ~clr_m) | set_m;

  assign q_o = q;

  assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_m != '0) |=> ((q & $past(set_m)) == $past(set_m)));
  assert_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i |=> ((q & $past(clr_i & ~set_i & MASK)) == '0));
  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_we_i && set_m == '0) |=> $stable(q));
endmodule

// File: rtl/sd_rsp_timer.sv
module sd_rsp_timer #(
  parameter int  TMO = 64,
  localparam int CW  = $clog2(TMO)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic issue_i,
  input  logic rsp_i,
  input  logic tick_i,
  output logic tmo_o
);
  localparam logic [CW-1:0] LAST = CW'(TMO - 1);

  logic          run;
  logic [CW-1:0] cnt;

  assign tmo_o = run && tick_i && (cnt == LAST) && !rsp_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (issue_i) begin
      run <= 1'b1;
      cnt <= '0;
    end else if (rsp_i || tmo_o) begin
      run <= 1'b0;
    end else if (run && tick_i) begin
      cnt <= cnt + 1'b1;
    end

  assert_single_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_o |=> !tmo_o);
  assert_rsp_cancel_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_i && !issue_i) |=> !tmo_o);
  assert_tick_only_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_o |-> tick_i);
endmodule

// File: rtl/sd_status_unit.sv
module sd_status_unit
  import sd_stat_pkg::*;
#(
  parameter int  DEPTH     = 16,
  parameter int  FC_MARGIN = 2,
  parameter int  TMO       = 64,
  localparam int CW        = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CW-1:0]     tx_count_i,
  input  logic [CW-1:0]     rx_count_i,
  input  logic              flow_ctrl_i,
  input  logic              cmd_busy_i,
  input  logic              tx_busy_i,
  input  logic              rx_busy_i,
  input  logic [EVT_W-1:0]  evt_i,
  input  logic              cmd_issue_i,
  input  logic              ck_tick_i,
  input  logic              clr_we_i,
  input  logic [STAT_W-1:0] clr_data_i,
  output logic [STAT_W-1:0] status_o
);
  localparam logic [EVT_W-1:0] EVT_IGN = EVT_W'((1 << B_CMD_TMO) | (1 << B_RSVD));

  fifo_lvl_t         lvl;
  logic              tmo;
  logic              rsp;
  logic [STAT_W-1:0] set_v, sticky_q;

  sd_fifo_levels #(.DEPTH(DEPTH), .FC_MARGIN(FC_MARGIN)) u_levels (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tx_cnt_i(tx_count_i),
    .rx_cnt_i(rx_count_i),
    .flow_i  (flow_ctrl_i),
    .lvl_o   (lvl)
  );

  assign rsp = evt_i[B_RSP_OK] | evt_i[B_CMD_CRC];

  sd_rsp_timer #(.TMO(TMO)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .issue_i(cmd_issue_i),
    .rsp_i  (rsp),
    .tick_i (ck_tick_i),
    .tmo_o  (tmo)
  );

  // bit 2 is owned by the timer, bit 9 is reserved
  assign set_v = STAT_W'(evt_i & ~EVT_IGN) | (STAT_W'(tmo) << B_CMD_TMO);

  sd_sticky_bank #(.W(STAT_W), .MASK(STICKY_MASK)) u_sticky (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (set_v),
    .clr_we_i(clr_we_i),
    .clr_i   (clr_data_i),
    .q_o     (sticky_q)
  );

  assign status_o = sticky_q |
                    {11'b0, lvl, rx_busy_i, tx_busy_i, cmd_busy_i, 11'b0};

  assert_reserved_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[31:21] == '0) && !status_o[B_RSVD]);
  assert_live_act_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[B_CMD_ACT] == cmd_busy_i);
endmodule

// File: tb/sd_status_unit_bench.sv
`timescale 1ns/1ps
module sd_status_unit_bench;
  logic        clk = 0, rst_ni = 0;
  logic [4:0]  tx_count = 0, rx_count = 0;
  logic        flow = 0, cmd_busy = 0, tx_busy = 0, rx_busy = 0;
  logic [10:0] evt = 0;
  logic        cmd_issue = 0, ck_tick = 1, clr_we = 0;
  logic [31:0] clr_data = 0, status;
  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sd_status_unit u_sd_status_unit (
    .clk_i(clk), .rst_ni(rst_ni), .tx_count_i(tx_count), .rx_count_i(rx_count),
    .flow_ctrl_i(flow), .cmd_busy_i(cmd_busy), .tx_busy_i(tx_busy),
    .rx_busy_i(rx_busy), .evt_i(evt), .cmd_issue_i(cmd_issue),
    .ck_tick_i(ck_tick), .clr_we_i(clr_we), .clr_data_i(clr_data),
    .status_o(status)
  );

  // {flow, tx, rx, expected bits 20..14}
  localparam logic [17:0] VEC [10] = '{
    {1'b0, 5'd0,  5'd0,  7'b0110001},
    {1'b0, 5'd16, 5'd16, 7'b1001110},
    {1'b0, 5'd2,  5'd14, 7'b1000011},
    {1'b1, 5'd2,  5'd14, 7'b1011011},
    {1'b1, 5'd3,  5'd13, 7'b1000011},
    {1'b0, 5'd8,  5'd8,  7'b1000011},
    {1'b0, 5'd9,  5'd7,  7'b1000000},
    {1'b1, 5'd0,  5'd16, 7'b0011011},
    {1'b0, 5'd1,  5'd15, 7'b1000011},
    {1'b1, 5'd16, 5'd1,  7'b1000100}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clear(input logic [31:0] m);
    clr_we = 1; clr_data = m;
    cyc(1);
    clr_we = 0; clr_data = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_ni = 1;
    cyc(1);
    chk("R1 reset", status, 32'h000C_4000);

    // R2 R3 R4 level table
    for (int i = 0; i < 10; i++) begin
      {flow, tx_count, rx_count} = VEC[i][17:7];
      #1;
      chk("R2 R3 R4 levels", {25'b0, status[20:14]}, {25'b0, VEC[i][6:0]});
    end

    flow = 0; tx_count = 5; rx_count = 5;
    cmd_busy = 1; tx_busy = 1; rx_busy = 1;
    #1;
    chk("R8 activity", status, 32'h0010_7800);

    evt = 11'h7FF;
    cyc(1);
    evt = 0;
    chk("R5 R7 capture", status, 32'h0010_7DFB);
    cyc(3);
    chk("R5 hold", status, 32'h0010_7DFB);
    clear(32'h0);
    chk("R6 zero write", status, 32'h0010_7DFB);
    clear(32'h3);
    chk("R6 partial clear", status, 32'h0010_7DF8);
    clear(32'hFFFF_FFFF);
    chk("R8 clear all keeps live", status, 32'h0010_7800);

    evt = 11'h080; clr_we = 1; clr_data = 32'hFFFF_FFFF;
    cyc(1);
    evt = 0; clr_we = 0; clr_data = 0;
    chk("R9 set wins", status, 32'h0010_7880);
    clear(32'h80);
    chk("R6 clear after collide", status, 32'h0010_7800);

    // R10 timeout with steady tick
    cmd_issue = 1;
    cyc(1);
    cmd_issue = 0;
    cyc(63);
    chk("R10 before expiry", {31'b0, status[2]}, 32'h0);
    cyc(1);
    chk("R10 expiry", {31'b0, status[2]}, 32'h1);
    clear(32'h4);
    cyc(70);
    chk("R10 single shot", {31'b0, status[2]}, 32'h0);

    // R11 early response cancels
    cmd_issue = 1;
    cyc(1);
    cmd_issue = 0;
    cyc(30);
    evt = 11'h040;
    cyc(1);
    evt = 0;
    clear(32'h40);
    cyc(80);
    chk("R11 cancel", {31'b0, status[2]}, 32'h0);

    // R12 tick every other cycle
    ck_tick = 0;
    cmd_issue = 1;
    cyc(1);
    cmd_issue = 0;
    for (int n = 0; n < 64; n++) begin
      ck_tick = 1;
      cyc(1);
      ck_tick = 0;
      if (n == 62) chk("R12 63 ticks", {31'b0, status[2]}, 32'h0);
      cyc(1);
    end
    chk("R12 64 ticks", {31'b0, status[2]}, 32'h1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule